// File: doc/BRIEF.md
# Data Address Access Comparator

This block watches the data-side memory accesses of a processor pipeline and flags those whose address hits one of two programmed watch addresses. Each access arrives as an address with a valid strobe and a direction bit. Loads are treated as reads and stores as writes. Four enable bits pick which register and direction pairs may raise an event. The event flags are combinational from the access inputs, so the pipeline sees the hit in the same cycle the address is presented, before the access completes.

A mode bit chooses how the two watch registers are used. In exact mode, each register is checked for equality on its own. In range mode, the two registers bound a single half-open window, with the lower bound included and the upper bound excluded. Every event also sets a sticky status bit. Status bits stay set until cleared with a write-one-to-clear strobe.

Configuration is loaded all at once through a single write strobe. The new values take effect from the following cycle.

Top module: `dwatch_top`

## Requirements
- R1: The event vector `evt` is combinational from `acc_vld`, `acc_wr` and `acc_addr` together with the stored configuration. A hit shows in the same cycle its address is presented.
- R2: The bit layout of `evt`, `sts`, `cfg_en` and `sts_clr` is fixed: bit 0 is a read hit on register 1, bit 1 is a read hit on register 2, bit 2 is a write hit on register 1, and bit 3 is a write hit on register 2. In exact mode (`rng`=0), `evt[0]` and `evt[2]` fire when the address equals register 1, and `evt[1]` and `evt[3]` fire when it equals register 2. When both registers hold the same address, both bits of that direction fire.
- R3: `acc_wr`=0 marks a load and is a read. `acc_wr`=1 marks a store and is a write. A read never raises bits 2 or 3. A write never raises bits 0 or 1.
- R4: In range mode (`rng`=1), an access hits when register 1 ≤ address < register 2, compared unsigned. A read hit raises bit 0 and a write hit raises bit 2. Bits 1 and 3 stay 0. If register 2 ≤ register 1, the window is empty.
- R5: An event bit can fire only when its enable bit is 1. When all enables are 0, no event fires.
- R6: While `acc_vld` is 0, `evt` is 0 and the status does not gain any bits.
- R7: At each clock edge, every raised `evt` bit sets the matching `sts` bit. A status bit is never set without an event, and it holds until it is cleared.
- R8: A 1 on a `sts_clr` bit clears that status bit at the next edge. If an event for the same bit occurs in the same cycle, the set wins and the bit stays 1.
- R9: Reset clears both registers, the enables, the mode bit and all status bits.
- R10: A `cfg_wr` pulse loads `cfg_da1`, `cfg_da2`, `cfg_en` and `cfg_rng` at the clock edge. Accesses in the cycle of the pulse are still compared against the old configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for all configuration fields |
| cfg_da1 | input | ADDR_W | Watch register 1 value (range lower bound) |
| cfg_da2 | input | ADDR_W | Watch register 2 value (range upper bound, excluded) |
| cfg_en | input | 4 | Event enables, bit layout as in R2 |
| cfg_rng | input | 1 | 0 = two exact compares, 1 = one range compare |
| acc_vld | input | 1 | Access valid strobe |
| acc_wr | input | 1 | Access direction: 0 = load/read, 1 = store/write |
| acc_addr | input | ADDR_W | Access data address |
| sts_clr | input | 4 | Write-one-to-clear mask for status bits |
| evt | output | 4 | Per-type event flags for the current access |
| sts | output | 4 | Sticky status bits |

## Verification
Two functions can act on the same status bit in the same cycle: setting it from a fresh hit and clearing it through `sts_clr`. The address sweeps drive clear masks at regular intervals that fall on hitting addresses as well as missing ones. The bench's status model applies clear first and then set, so any case where the clear wins shows up as a status mismatch. A configuration load can also coincide with an access whose address matches only the new configuration. That access is expected to produce no event in that cycle.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
   localparam int NUM_EVT = 4;
   localparam int NUM_REG = 2;
   // event bit positions: direction-major, register-minor
   localparam int IDX_RD1 = 0;
   localparam int IDX_RD2 = 1;
   localparam int IDX_WR1 = 2;
   localparam int IDX_WR2 = 3;
   typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/dwatch_cfg.sv
module dwatch_cfg #(
   parameter int ADDR_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [ADDR_W-1:0]       cfg_da1,
   input  logic [ADDR_W-1:0]       cfg_da2,
   input  dwatch_pkg::evt_vec_t    cfg_en,
   input  logic                    cfg_rng,
   output logic [ADDR_W-1:0]       da1_q,
   output logic [ADDR_W-1:0]       da2_q,
   output dwatch_pkg::evt_vec_t    en_q,
   output logic                    rng_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         da1_q <= '0;
         da2_q <= '0;
         en_q  <= '0;
         rng_q <= 1'b0;
      end else if (cfg_wr) begin
         da1_q <= cfg_da1;
         da2_q <= cfg_da2;
         en_q  <= cfg_en;
         rng_q <= cfg_rng;
      end
   end
endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp #(
   parameter int ADDR_W   = 32,
   parameter bit RANGE_EN = 1'b1
) (
   input  logic                    acc_vld,
   input  logic                    acc_wr,
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic [ADDR_W-1:0]       da1,
   input  logic [ADDR_W-1:0]       da2,
   input  dwatch_pkg::evt_vec_t    en,
   input  logic                    rng,
   output dwatch_pkg::evt_vec_t    evt
);
   import dwatch_pkg::*;

   logic [NUM_REG-1:0]    eq_hit;
   logic [ADDR_W-1:0]     regs [NUM_REG];
   logic                  rng_act;
   logic                  in_win;
   evt_vec_t              raw;

   assign regs[0] = da1;
   assign regs[1] = da2;

   // one equality comparator per watch register
   for (genvar g = 0; g < NUM_REG; g++) begin : g_eq
      assign eq_hit[g] = (acc_addr == regs[g]);
   end

   // range variant is optional hardware
   if (RANGE_EN) begin : g_rng
      assign rng_act = rng;
      assign in_win  = (acc_addr >= da1) && (acc_addr < da2);
   end else begin : g_norng
      logic unused_rng;
      assign unused_rng = rng;
      assign rng_act    = 1'b0;
      assign in_win     = 1'b0;
   end

   always_comb begin
      raw = '0;
      if (rng_act) begin
         raw[IDX_RD1] = ~acc_wr & in_win;
         raw[IDX_WR1] =  acc_wr & in_win;
      end else begin
         raw[IDX_RD1] = ~acc_wr & eq_hit[0];
         raw[IDX_RD2] = ~acc_wr & eq_hit[1];
         raw[IDX_WR1] =  acc_wr & eq_hit[0];
         raw[IDX_WR2] =  acc_wr & eq_hit[1];
      end
   end

   assign evt = acc_vld ? (raw & en) : '0;
endmodule

// File: rtl/dwatch_sts.sv
module dwatch_sts (
   input  logic                    clk,
   input  logic                    rst_n,
   input  dwatch_pkg::evt_vec_t    evt,
   input  dwatch_pkg::evt_vec_t    clr,
   output dwatch_pkg::evt_vec_t    sts
);
   import dwatch_pkg::*;

   for (genvar b = 0; b < NUM_EVT; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sts[b] <= 1'b0;
         else if (evt[b]) sts[b] <= 1'b1;   // set beats clear
         else if (clr[b]) sts[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/dwatch_top.sv
module dwatch_top #(
   parameter int ADDR_W   = 32,
   parameter bit RANGE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [ADDR_W-1:0]    cfg_da1,
   input  logic [ADDR_W-1:0]    cfg_da2,
   input  logic [3:0]           cfg_en,
   input  logic                 cfg_rng,
   input  logic                 acc_vld,
   input  logic                 acc_wr,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic [3:0]           sts_clr,
   output logic [3:0]           evt,
   output logic [3:0]           sts
);
   import dwatch_pkg::*;

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_w
      $error("dwatch_top: ADDR_W out of supported span");
   end
   if (NUM_EVT != 4) begin : g_bad_n
      $error("dwatch_top: event count must be four");
   end

   logic [ADDR_W-1:0] da1_q;
   logic [ADDR_W-1:0] da2_q;
   evt_vec_t          en_q;
   logic              rng_q;
   evt_vec_t          evt_w;
   evt_vec_t          sts_w;

   dwatch_cfg #(.ADDR_W(ADDR_W)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_da1 (cfg_da1),
      .cfg_da2 (cfg_da2),
      .cfg_en  (cfg_en),
      .cfg_rng (cfg_rng),
      .da1_q   (da1_q),
      .da2_q   (da2_q),
      .en_q    (en_q),
      .rng_q   (rng_q)
   );

   dwatch_cmp #(.ADDR_W(ADDR_W), .RANGE_EN(RANGE_EN)) cmp_i (
      .acc_vld  (acc_vld),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .da1      (da1_q),
      .da2      (da2_q),
      .en       (en_q),
      .rng      (rng_q),
      .evt      (evt_w)
   );

   dwatch_sts sts_i (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_w),
      .clr   (sts_clr),
      .sts   (sts_w)
   );

   assign evt = evt_w;
   assign sts = sts_w;
endmodule

// File: rtl/dwatch_chk.sv
module dwatch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_vld,
   input logic       acc_wr,
   input logic [3:0] sts_clr,
   input logic [3:0] evt,
   input logic [3:0] sts,
   input logic [3:0] en_q,
   input logic       rng_q
);
   // R6
   idle_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld |-> (evt == 4'b0000));

   // R3
   read_no_wr_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !acc_wr) |-> (evt[3:2] == 2'b00));

   // R3
   write_no_rd_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_wr) |-> (evt[1:0] == 2'b00));

   // R4
   range_reg2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rng_q |-> (evt[1] == 1'b0 && evt[3] == 1'b0));

   // R5
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & ~en_q) == 4'b0000));

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(sts) & ~$past(sts_clr)) & ~sts) == 4'b0000));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt) & ~sts) == 4'b0000));

   // R7
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts & ~$past(sts) & ~$past(evt)) == 4'b0000));
endmodule

bind dwatch_top dwatch_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .acc_vld (acc_vld),
   .acc_wr  (acc_wr),
   .sts_clr (sts_clr),
   .evt     (evt),
   .sts     (sts),
   .en_q    (en_q),
   .rng_q   (rng_q)
);

// File: tb/dwatch_top_tb_top.sv
`timescale 1ns/1ps
module dwatch_top_tb_top;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [AW-1:0] cfg_da1 = '0;
   logic [AW-1:0] cfg_da2 = '0;
   logic [3:0]    cfg_en = '0;
   logic          cfg_rng = 1'b0;
   logic          acc_vld = 1'b0;
   logic          acc_wr = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [3:0]    sts_clr = '0;
   logic [3:0]    evt;
   logic [3:0]    sts;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the programmed state
   logic [AW-1:0] m_da1 = '0;
   logic [AW-1:0] m_da2 = '0;
   logic [3:0]    m_en = '0;
   logic          m_rng = 1'b0;
   logic [3:0]    m_sts = '0;

   always #4 clk = ~clk;

   dwatch_top #(.ADDR_W(AW), .RANGE_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_da1(cfg_da1),
      .cfg_da2(cfg_da2), .cfg_en(cfg_en), .cfg_rng(cfg_rng),
      .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
      .sts_clr(sts_clr), .evt(evt), .sts(sts)
   );

   function automatic logic [3:0] expect_evt(logic v, logic w, logic [AW-1:0] a);
      logic [3:0] e;
      logic       win;
      e = 4'b0000;
      if (v) begin
         if (m_rng) begin
            win  = (a >= m_da1) && (a < m_da2);
            e[0] = !w && win;
            e[2] =  w && win;
         end else begin
            e[0] = !w && (a == m_da1);
            e[1] = !w && (a == m_da2);
            e[2] =  w && (a == m_da1);
            e[3] =  w && (a == m_da2);
         end
      end
      return e & m_en;
   endfunction

   task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b addr=%h wr=%b", tag, act, exp, acc_addr, acc_wr);
      end
   endtask

   // one access cycle: event checked mid-cycle, status after the edge
   task automatic step(string tag, logic v, logic w, logic [AW-1:0] a, logic [3:0] clr);
      logic [3:0] e;
      @(negedge clk);
      acc_vld = v; acc_wr = w; acc_addr = a; sts_clr = clr;
      e = expect_evt(v, w, a);
      #1 check4({tag, " evt R1 R2 R5 R6"}, evt, e);
      @(posedge clk);
      m_sts = (m_sts & ~clr) | e;
      #1 check4({tag, " sts R7 R8"}, sts, m_sts);
   endtask

   // load config; an access aimed at the new register 1 runs in the same cycle (R10)
   task automatic load_cfg(logic [AW-1:0] d1, logic [AW-1:0] d2, logic [3:0] en, logic r);
      logic [3:0] e;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_da1 = d1; cfg_da2 = d2; cfg_en = en; cfg_rng = r;
      acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = d1; sts_clr = 4'b0000;
      e = expect_evt(1'b1, 1'b0, d1);
      #1 check4("cfg cycle uses old config R10", evt, e);
      @(posedge clk);
      m_sts = m_sts | e;
      m_da1 = d1; m_da2 = d2; m_en = en; m_rng = r;
      #1 check4("cfg cycle sts R10", sts, m_sts);
      @(negedge clk);
      cfg_wr = 1'b0;
      acc_vld = 1'b0;
   endtask

   task automatic sweep(string tag);
      logic [3:0] clr;
      for (int a = 0; a < (1 << AW); a++) begin
         for (int w = 0; w < 2; w++) begin
            if (a % 7 == 0)       clr = 4'b1111;
            else if (a % 11 == 0) clr = 4'b0101;
            else                  clr = 4'b0000;
            step(tag, ((a + w) % 5) != 0, w[0], a[AW-1:0], clr);
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      acc_vld = 1'b0; cfg_wr = 1'b0; sts_clr = 4'b0000;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_da1 = '0; m_da2 = '0; m_en = '0; m_rng = 1'b0; m_sts = '0;
   endtask

   initial begin
      do_reset();
      #1 check4("reset sts R9", sts, 4'b0000);
      // registers are 0 and would match address 0 if enables survived reset
      step("reset enables R9", 1'b1, 1'b0, '0, 4'b0000);
      step("reset enables wr R9", 1'b1, 1'b1, '0, 4'b0000);

      load_cfg(8'h20, 8'h9C, 4'b1111, 1'b0);  sweep("exact two R2 R3");
      load_cfg(8'h40, 8'h40, 4'b1111, 1'b0);  sweep("exact same R2");
      load_cfg(8'hFF, 8'h00, 4'b0101, 1'b0);  sweep("exact reg1 only R5");
      load_cfg(8'h10, 8'h11, 4'b1010, 1'b0);  sweep("exact reg2 only R5");
      load_cfg(8'h33, 8'h44, 4'b0000, 1'b0);  sweep("all off R5");
      load_cfg(8'h30, 8'h50, 4'b1111, 1'b1);  sweep("range R4");
      load_cfg(8'h00, 8'hFF, 4'b0100, 1'b1);  sweep("range wide wr R4");
      load_cfg(8'h80, 8'h80, 4'b1111, 1'b1);  sweep("range empty R4");
      load_cfg(8'h90, 8'h10, 4'b1111, 1'b1);  sweep("range inverted R4");

      // status set then reset clears everything again
      load_cfg(8'h05, 8'h06, 4'b1111, 1'b0);
      step("preload R7", 1'b1, 1'b1, 8'h06, 4'b0000);
      do_reset();
      #1 check4("mid reset sts R9", sts, 4'b0000);
      step("mid reset enables R9", 1'b1, 1'b1, 8'h06, 4'b0000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule